// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of the slave side of a three-wire serial EEPROM. It has a chip select, a serial clock, a data input and a data output. The output has a separate drive enable, so the output pin can be released. The storage is a register array of 16-bit words. The address width sets the depth. The host shifts in a start bit, an opcode and an address, and then a data word where the command needs one. Reads return one word. Program commands run as a self-timed cycle that a count of system clocks measures.

The pins are sampled on the system clock and edges are detected from those samples. The inputs must therefore come from the same clock domain, and each serial clock phase must last at least one system clock. Every program command becomes armed when its frame is complete. These commands are single-word write, single-word erase, erase-all and write-all. The self-timed cycle begins at the falling edge of chip select and needs no serial clocks. The host can raise chip select again after the minimum deselect time. It then polls the data output to see whether the part is busy or ready.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is low, the data output drive enable is 0 (high impedance).
- R2: A frame starts with a 1 on the data input, sampled at a rising serial clock edge. Any number of 0s before it are ignored. Next come 2 opcode bits and ADDR_W address bits, most significant bit first. The opcodes are: 10 read, 01 write, 11 erase and 00 special. For special, the two top address bits choose the command: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R3: Read: DO drives 0 from the rising edge that takes the last address bit. On each of the next 16 rising edges it presents the next bit of the word, most significant bit first. After that it holds the last bit until chip select falls.
- R4: Write takes 16 data bits, most significant bit first, and stores them at the address. Erase stores all ones at the address.
- R5: The block powers up with writes disabled. Write, erase, erase-all and write-all have no effect unless the most recent of enable and disable was enable.
- R6: An armed program command starts its cycle on the chip select falling edge. The cycle lasts WR_CYCLES clocks with no serial clock activity, and the array changes at its end.
- R7: Erase-all sets every bit of every word to 1.
- R8: Write-all stores the same data word in every location, whatever the locations held before.
- R9: Chip select may rise after a cycle has started and after at least CS_MIN clocks low. DO is then driven: 0 while busy and 1 once ready. It stays driven until a start bit is taken or chip select falls. If chip select rises after fewer than CS_MIN low clocks, DO stays undriven.
- R10: Serial clock edges during a program cycle are ignored: no bit of a command sent then takes effect.
- R11: A frame cut short by chip select falling has no effect, and no program cycle follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for sampling and timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data input |
| do_o | output | 1 | Serial data output value |
| do_en_o | output | 1 | Drive enable for do_o (0 = high impedance) |

## Verification
Two functions can fall on the same clock: the end of a program cycle, and the status poll or serial clocking that the host does meanwhile.

The bench raises chip select during a cycle and watches the ready transition. It also streams a complete disable frame while the part is busy. It then proves the frame was ignored by doing a later successful write.

A behavioural model in the bench predicts the drive enable and the output on every clock. A bulk operation that ends while status is shown must therefore flip DO in exactly the predicted cycle.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_READ,
    ST_ARMED,
    ST_HOLD
  } mw_state_e;

  typedef enum logic [1:0] {
    K_WRITE,
    K_ERASE,
    K_ERAL,
    K_WRAL
  } mw_kind_e;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_DIS  = 2'b00;
  localparam logic [1:0] SUB_WRAL = 2'b01;
  localparam logic [1:0] SUB_ERAL = 2'b10;
  localparam logic [1:0] SUB_EN   = 2'b11;

endpackage

// File: rtl/mw_pins.sv
module mw_pins #(
  parameter int CS_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  output logic sk_rise_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic desel_ok_o
);

  localparam int DW = $clog2(CS_MIN + 1) + 1;

  logic          sk_q, cs_q;
  logic [DW-1:0] low_q, low_d;

  always_comb begin
    low_d = low_q;
    if (cs_i)
      low_d = '0;
    else if (low_q < DW'(CS_MIN))
      low_d = low_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q  <= 1'b0;
      cs_q  <= 1'b0;
      low_q <= '0;
    end else begin
      sk_q  <= sk_i;
      cs_q  <= cs_i;
      low_q <= low_d;
    end
  end

  assign sk_rise_o  = sk_i & ~sk_q;
  assign cs_fall_o  = ~cs_i & cs_q;
  assign cs_rise_o  = cs_i & ~cs_q;
  assign desel_ok_o = (low_q >= DW'(CS_MIN));

endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o,
  output logic commit_o
);

  localparam int CW = $clog2(WR_CYCLES + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == CW'(WR_CYCLES - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (go_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (last)
        busy_d = 1'b0;
      else
        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q & last;

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_q);

endmodule

// File: rtl/mw_array.sv
module mw_array import mw_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  mw_kind_e          kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_word_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              bulk;
  logic [DATA_W-1:0] val;

  always_comb begin
    bulk = (kind_i == K_ERAL) || (kind_i == K_WRAL);
    val  = ((kind_i == K_ERASE) || (kind_i == K_ERAL)) ? '1 : data_i;
  end

  always_ff @(posedge clk) begin
    if (commit_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (bulk || (addr_i == ADDR_W'(i)))
          mem[i] <= val;
      end
    end
  end

  assign rd_word_o = mem[rd_addr_i];

  // R7
  eral_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && kind_i == K_ERAL) |=> (mem[0] == '1 && mem[DEPTH-1] == '1));

  // R8
  wral_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && kind_i == K_WRAL) |=>
      (mem[0] == $past(data_i) && mem[DEPTH-1] == $past(data_i)));

  // R4
  word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && kind_i == K_WRITE) |=> (mem[$past(addr_i)] == $past(data_i)));

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl import mw_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              di_i,
  input  logic              sk_rise_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              desel_ok_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              prog_go_o,
  output mw_kind_e          prog_kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              do_o,
  output logic              do_en_o
);

  localparam int CMD_W   = 2 + ADDR_W;
  localparam int CNT_MAX = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  mw_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CMD_W-1:0]  sh_q, sh_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  mw_kind_e          kind_q, kind_d;
  logic              wen_q, wen_d;
  logic              pend_q, pend_d;
  logic              stat_q, stat_d;
  logic              rd_q, rd_d;
  logic              bit_q, bit_d;
  logic              go;

  logic [CMD_W-1:0]  frame;
  logic [1:0]        op, sub;

  assign frame = {sh_q[CMD_W-2:0], di_i};
  assign op    = frame[CMD_W-1 -: 2];
  assign sub   = frame[ADDR_W-1 -: 2];

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    dat_d  = dat_q;
    addr_d = addr_q;
    kind_d = kind_q;
    wen_d  = wen_q;
    pend_d = pend_q;
    stat_d = stat_q;
    rd_d   = rd_q;
    bit_d  = bit_q;
    go     = 1'b0;

    if (!cs_i) begin
      if (cs_fall_i && st_q == ST_ARMED) begin
        go     = 1'b1;
        pend_d = 1'b1;
      end
      st_d   = ST_IDLE;
      rd_d   = 1'b0;
      stat_d = 1'b0;
    end else if (cs_rise_i) begin
      stat_d = pend_q & desel_ok_i;
    end else if (sk_rise_i && !busy_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (di_i) begin
            st_d   = ST_CMD;
            cnt_d  = '0;
            stat_d = 1'b0;
            pend_d = 1'b0;
          end
        end
        ST_CMD: begin
          sh_d  = frame;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(CMD_W - 1)) begin
            addr_d = frame[ADDR_W-1:0];
            cnt_d  = '0;
            st_d   = ST_HOLD;
            unique case (op)
              OP_READ: begin
                st_d  = ST_READ;
                rd_d  = 1'b1;
                bit_d = 1'b0;
              end
              OP_WRITE: begin
                kind_d = K_WRITE;
                if (wen_q) st_d = ST_DATA;
              end
              OP_ERASE: begin
                kind_d = K_ERASE;
                if (wen_q) st_d = ST_ARMED;
              end
              default: begin
                unique case (sub)
                  SUB_EN:  wen_d = 1'b1;
                  SUB_DIS: wen_d = 1'b0;
                  SUB_ERAL: begin
                    kind_d = K_ERAL;
                    if (wen_q) st_d = ST_ARMED;
                  end
                  default: begin
                    kind_d = K_WRAL;
                    if (wen_q) st_d = ST_DATA;
                  end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          dat_d = {dat_q[DATA_W-2:0], di_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1))
            st_d = ST_ARMED;
        end
        ST_READ: begin
          if (cnt_q == '0) begin
            bit_d = rd_word_i[DATA_W-1];
            dat_d = {rd_word_i[DATA_W-2:0], 1'b0};
            cnt_d = 1'b1;
          end else if (cnt_q < CNT_W'(DATA_W)) begin
            bit_d = dat_q[DATA_W-1];
            dat_d = {dat_q[DATA_W-2:0], 1'b0};
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      dat_q  <= '0;
      addr_q <= '0;
      kind_q <= K_WRITE;
      wen_q  <= 1'b0;
      pend_q <= 1'b0;
      stat_q <= 1'b0;
      rd_q   <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      dat_q  <= dat_d;
      addr_q <= addr_d;
      kind_q <= kind_d;
      wen_q  <= wen_d;
      pend_q <= pend_d;
      stat_q <= stat_d;
      rd_q   <= rd_d;
      bit_q  <= bit_d;
    end
  end

  assign prog_go_o   = go;
  assign prog_kind_o = kind_q;
  assign addr_o      = addr_q;
  assign data_o      = dat_q;
  assign do_en_o     = cs_i & (stat_q | rd_q);
  assign do_o        = stat_q ? ~busy_i : bit_q;

  // R5
  go_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go_o |-> wen_q);

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom import mw_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int WR_CYCLES = 200,
  parameter int CS_MIN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_en_o
);

  logic              rst_s1, rst_s;
  logic              sk_rise, cs_fall, cs_rise, desel_ok;
  logic              busy, commit, go;
  mw_kind_e          kind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data, rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  mw_pins #(.CS_MIN(CS_MIN)) u_pins (
    .clk(clk), .rst_n(rst_s), .cs_i(cs_i), .sk_i(sk_i),
    .sk_rise_o(sk_rise), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .desel_ok_o(desel_ok)
  );

  mw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .cs_i(cs_i), .di_i(di_i),
    .sk_rise_i(sk_rise), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .desel_ok_i(desel_ok), .busy_i(busy), .rd_word_i(rd_word),
    .prog_go_o(go), .prog_kind_o(kind), .addr_o(addr), .data_o(data),
    .do_o(do_o), .do_en_o(do_en_o)
  );

  mw_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_s), .go_i(go), .busy_o(busy), .commit_o(commit)
  );

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_s), .commit_i(commit), .kind_i(kind),
    .addr_i(addr), .data_i(data), .rd_addr_i(addr), .rd_word_o(rd_word)
  );

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(busy) |-> $past(cs_fall));

endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  localparam int AW = 8, DW = 16, WRC = 60, CSM = 4, NW = 256;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w, en_w;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .WR_CYCLES(WRC), .CS_MIN(CSM)) dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_en_o(en_w)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] mm [NW];
  int ph, nbits, hdr, wd, maddr, kind, left, lowc, rdidx;
  bit wen, busy, pend, stat, rd, outbit, psk, pcs;

  task automatic model_commit();
    case (kind)
      0: mm[maddr] = wd[15:0];
      1: mm[maddr] = 16'hFFFF;
      2: for (int i = 0; i < NW; i++) mm[i] = 16'hFFFF;
      default: for (int i = 0; i < NW; i++) mm[i] = wd[15:0];
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; wen = 0; busy = 0; pend = 0; stat = 0; rd = 0;
      lowc = 0; psk = 0; pcs = 0; outbit = 0; nbits = 0; hdr = 0;
    end else begin
      bit skr, csf, csr, wasbusy;
      skr = sk && !psk; csf = !cs && pcs; csr = cs && !pcs; wasbusy = busy;
      if (busy) begin
        left--;
        if (left == 0) begin busy = 0; model_commit(); end
      end
      if (!cs) begin
        if (csf && ph == 4) begin busy = 1; left = WRC; pend = 1; end
        ph = 0; rd = 0; stat = 0;
      end else if (csr) begin
        stat = pend && (lowc >= CSM);
      end else if (skr && !wasbusy) begin
        case (ph)
          0: if (di) begin ph = 1; hdr = 0; nbits = 0; stat = 0; pend = 0; end
          1: begin
            hdr = hdr * 2 + int'(di); nbits++;
            if (nbits == AW + 2) begin
              int op, top;
              op = hdr >> AW; maddr = hdr % NW; top = maddr >> (AW - 2);
              ph = 5; nbits = 0; wd = 0;
              if (op == 2) begin ph = 3; rd = 1; outbit = 0; rdidx = 0; end
              else if (op == 1) begin kind = 0; if (wen) ph = 2; end
              else if (op == 3) begin kind = 1; if (wen) ph = 4; end
              else if (top == 3) wen = 1;
              else if (top == 0) wen = 0;
              else if (top == 2) begin kind = 2; if (wen) ph = 4; end
              else begin kind = 3; if (wen) ph = 2; end
            end
          end
          2: begin
            wd = wd * 2 + int'(di); nbits++;
            if (nbits == DW) ph = 4;
          end
          3: if (rdidx < DW) begin outbit = mm[maddr][DW-1-rdidx]; rdidx++; end
          default: ;
        endcase
      end
      if (cs) lowc = 0; else if (lowc < CSM) lowc++;
      psk = sk; pcs = cs;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit een;
      string tag;
      een = cs && (stat || rd);
      tag = !cs ? "R1 standby" : stat ? "R9 status" : rd ? "R3 read" : "R2 frame";
      check(tag, {31'b0, en_w}, {31'b0, een});
      if (een) check(tag, {31'b0, do_w}, {31'b0, (stat ? !busy : outbit)});
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic clk_bit(bit b);
    di = b; tick(); sk = 1; tick(); sk = 0; tick();
  endtask

  task automatic frame(int lead, bit [1:0] op, bit [7:0] a);
    cs = 1; tick();
    repeat (lead) clk_bit(0);
    clk_bit(1);
    for (int i = 1; i >= 0; i--) clk_bit(op[i]);
    for (int i = AW - 1; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic word(bit [15:0] w);
    for (int i = DW - 1; i >= 0; i--) clk_bit(w[i]);
  endtask

  task automatic deselect();
    cs = 0; di = 0; tick(CSM + 2);
  endtask

  task automatic wait_ready(string req);
    int n;
    n = 0;
    cs = 1; tick();
    check(req, {31'b0, en_w}, 32'd1);
    check(req, {31'b0, do_w}, 32'd0);
    while (do_w !== 1'b1 && n < WRC + 10) begin tick(); n++; end
    check(req, {31'b0, do_w}, 32'd1);
    tick(3);
    check("R9 persists", {31'b0, do_w}, 32'd1);
    deselect();
  endtask

  task automatic rd_word(bit [7:0] a, output logic [15:0] w);
    frame(0, 2'b10, a);
    check("R3 dummy", {30'b0, en_w, do_w}, 32'd2);
    for (int i = DW - 1; i >= 0; i--) begin
      di = 0; tick(); sk = 1; tick(); w[i] = do_w; sk = 0; tick();
    end
    deselect();
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] w;
    tick(3);
    check("R1 reset", {31'b0, en_w}, 32'd0);
    rst_n = 1; tick(5);

    // R5: erase-all at power-up is ignored, no cycle and no status
    frame(0, 2'b00, 8'h80); deselect();
    cs = 1; tick(2);
    check("R5 no cycle", {31'b0, en_w}, 32'd0);
    deselect();

    // R7 / R6: enable then erase-all
    frame(0, 2'b00, 8'hC0); deselect();
    frame(0, 2'b00, 8'h80); deselect();
    wait_ready("R6 busy then ready");
    rd_word(8'h05, w); check("R7 word 05", w, 32'hFFFF);
    rd_word(8'hFF, w); check("R7 word FF", w, 32'hFFFF);

    // R5: disable then write ignored
    frame(0, 2'b00, 8'h00); deselect();
    frame(0, 2'b01, 8'h03); word(16'hAAAA); deselect();
    cs = 1; tick(2);
    check("R5 disabled no status", {31'b0, en_w}, 32'd0);
    deselect();
    rd_word(8'h03, w); check("R5 unchanged", w, 32'hFFFF);

    // R4: write and erase
    frame(0, 2'b00, 8'hC0); deselect();
    frame(0, 2'b01, 8'h03); word(16'hA5C3); deselect();
    wait_ready("R9 after write");
    rd_word(8'h03, w); check("R4 write", w, 32'hA5C3);
    rd_word(8'h04, w); check("R4 neighbour", w, 32'hFFFF);
    frame(0, 2'b11, 8'h03); deselect();
    wait_ready("R9 after erase");
    rd_word(8'h03, w); check("R4 erase", w, 32'hFFFF);

    // R2: leading zeros
    frame(3, 2'b01, 8'h55); word(16'h0F0F); deselect();
    wait_ready("R9 lead");
    rd_word(8'h55, w); check("R2 leading zeros", w, 32'h0F0F);

    // R3: extra clock after last bit holds the last bit
    frame(0, 2'b10, 8'h55);
    for (int i = 0; i < DW + 1; i++) begin
      di = 0; tick(); sk = 1; tick(); sk = 0; tick();
    end
    check("R3 hold last", {30'b0, en_w, do_w}, 32'd3);
    deselect();

    // R9 early raise, R10 frame during busy ignored
    frame(0, 2'b01, 8'h14); word(16'h7777);
    cs = 0; di = 0; tick(2);
    cs = 1; tick();
    check("R9 early raise", {31'b0, en_w}, 32'd0);
    cs = 0; tick(CSM + 1);
    cs = 1; tick();
    check("R9 busy", {30'b0, en_w, do_w}, 32'd2);
    clk_bit(1); clk_bit(0); clk_bit(0);
    for (int i = 0; i < AW; i++) clk_bit(0);
    check("R10 still busy", {30'b0, en_w, do_w}, 32'd2);
    for (int i = 0; i < WRC && do_w !== 1'b1; i++) tick();
    check("R9 ready", {30'b0, en_w, do_w}, 32'd3);
    deselect();
    frame(0, 2'b01, 8'h15); word(16'h4242); deselect();
    wait_ready("R10 enable kept");
    rd_word(8'h15, w); check("R10 write after busy frame", w, 32'h4242);
    rd_word(8'h14, w); check("R4 busy write", w, 32'h7777);

    // R8: write-all over mixed contents
    frame(0, 2'b00, 8'h40); word(16'h1E0F); deselect();
    wait_ready("R9 wral");
    rd_word(8'h00, w); check("R8 word 00", w, 32'h1E0F);
    rd_word(8'h14, w); check("R8 word 14", w, 32'h1E0F);
    rd_word(8'hFF, w); check("R8 word FF", w, 32'h1E0F);

    // R11: frame aborted mid-data
    frame(0, 2'b01, 8'h07);
    for (int i = 0; i < 8; i++) clk_bit(1);
    deselect();
    cs = 1; tick(2);
    check("R11 no cycle", {31'b0, en_w}, 32'd0);
    deselect();
    rd_word(8'h07, w); check("R11 unchanged", w, 32'h1E0F);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule